// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

This block records the moment an external signal changes. The capture pin first passes through a two-stage synchroniser. An optional run-length glitch filter may follow, and then an edge detector. When the detector sees the selected edge, the block copies the value of a free-running 16-bit timer count into a capture register and raises a sticky capture flag. If the capture interrupt is enabled, the flag drives an interrupt request.

An 8-bit control byte configures the block. It holds the filter enable, the edge polarity, the two upper bits of the timer waveform mode and the three clock-select bits. The clock-select bits are passed on to an external prescaler. The two lower waveform-mode bits arrive on a separate input. When the full 4-bit mode is one in which the capture register acts as the counter's top value, the pin is cut off from the capture path and no timestamps are taken.

Software clears the flag by pulsing a write-one-to-clear strobe. A capture that lands in the same cycle as the clear takes priority.

Top module: `edge_stamp_unit`

## Requirements
- R1: After reset, the control byte reads 0x00, the capture value is 0, and both the flag and the interrupt request are low.
- R2: The control byte is laid out as bit 7 filter enable, bit 6 edge select, bit 5 reserved, bits 4:3 waveform-mode bits 3:2, and bits 2:0 clock select. Bit 5 always reads 0, whatever was written. Bits 2:0 also appear on `clk_sel`.
- R3: With the filter off, a pin change is captured on the third rising clock edge after it. The capture register takes the `tmr_count` value sampled at that edge, and the flag is high from that edge onward.
- R4: With edge select 1, only rising edges capture. With edge select 0, only falling edges capture. The opposite edge leaves both the capture value and the flag unchanged.
- R5: With the filter on, a capture happens four clock cycles later than it would with the filter off.
- R6: With the filter on, a pin level that lasts fewer than four samples causes no capture.
- R7: A `flag_clr` pulse clears the flag. If a capture happens in the same cycle as the clear, the flag stays set.
- R8: `cap_irq` is high exactly while the flag is set and `cap_ie` is 1.
- R9: Writing a new edge-select value while the pin is steady causes no capture.
- R10: The waveform mode is {control bits 4:3, `wave_lo`}. In modes 8, 10, 12 and 14 (mode bit 3 set, mode bit 0 clear) no capture occurs. In other modes, such as 9, captures happen as normal.
- R11: With the filter on, a sample that matches the current filtered level restarts the run count. Two 3-sample pulses separated by one opposite sample therefore cause no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 1 | Asynchronous capture input |
| tmr_count | input | 16 | Free-running timer count to timestamp |
| wave_lo | input | 2 | Waveform-mode bits 1:0 |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write data |
| cfg_rdata | output | 8 | Control byte read-back |
| flag_clr | input | 1 | Write-one-to-clear pulse for the flag |
| cap_ie | input | 1 | Capture interrupt enable |
| clk_sel | output | 3 | Clock-select bits for the prescaler |
| cap_value | output | 16 | Captured timestamp |
| cap_flag | output | 1 | Capture flag |
| cap_irq | output | 1 | Interrupt request |

## Verification
Off-by-one latency is the first target. The bench predicts the exact timestamp for both the filtered and the unfiltered path, so a missing synchroniser stage or a filter that switches on its third sample shows up as a timestamp that is off by one or more counts. Glitch patterns are a second target: a run of three samples, and two such runs split by a single opposite sample. A filter that never restarts its run count would accept the second pattern and capture. The bench also covers the clear colliding with a capture, which catches a design where the clear wins and a timestamp is silently lost. It toggles edge select on a steady pin, which catches a detector that compares against the polarity instead of the pin level. Finally, it sweeps every waveform mode that uses the capture register as top, which catches a wrong mode decode.

// File: rtl/edge_stamp_pkg.sv
package edge_stamp_pkg;

  typedef struct packed {
    logic       filt_en;
    logic       edge_rise;
    logic [1:0] wave_hi;
    logic [2:0] clk_sel;
  } es_cfg_t;

  // Bit 5 of the byte is reserved and never stored.
  function automatic es_cfg_t cfg_from_byte(input logic [7:0] b);
    es_cfg_t c;
    c.filt_en   = b[7];
    c.edge_rise = b[6];
    c.wave_hi   = b[4:3];
    c.clk_sel   = b[2:0];
    return c;
  endfunction

  function automatic logic [7:0] cfg_to_byte(input es_cfg_t c);
    return {c.filt_en, c.edge_rise, 1'b0, c.wave_hi, c.clk_sel};
  endfunction

  // Modes that use the capture register as the counter top: 8, 10, 12, 14.
  function automatic logic mode_uses_cap_top(input logic [3:0] mode);
    return mode[3] & ~mode[0];
  endfunction

  // Edge qualification against the previous level.
  function automatic logic edge_hit(input logic now_lvl, input logic old_lvl,
                                    input logic want_rise);
    return want_rise ? (now_lvl & ~old_lvl) : (~now_lvl & old_lvl);
  endfunction

endpackage

// File: rtl/es_pin_sync.sv
module es_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], pin};
  end

  assign lvl = chain[STAGES-1];
endmodule

// File: rtl/es_glitch_filter.sv
module es_glitch_filter #(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp,
  output logic lvl
);
  localparam int CW = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] run_q;
  logic          lvl_q;
  logic          differs;

  assign differs = smp ^ lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      lvl_q <= 1'b0;
    end else if (!differs) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      run_q <= '0;
      lvl_q <= smp;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign lvl = lvl_q;
endmodule

// File: rtl/es_edge_detect.sv
module es_edge_detect
  import edge_stamp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic want_rise,
  input  logic enable,
  output logic hit
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign hit = enable & edge_hit(lvl, prev_q, want_rise);
endmodule

// File: rtl/es_cap_store.sv
module es_cap_store #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_evt,
  input  logic         clr,
  input  logic [W-1:0] count,
  output logic [W-1:0] value,
  output logic         flag
);
  logic [W-1:0] value_q;
  logic         flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (set_evt) value_q <= count;
      flag_q <= set_evt | (flag_q & ~clr);
    end
  end

  assign value = value_q;
  assign flag  = flag_q;
endmodule

// File: rtl/edge_stamp_unit.sv
module edge_stamp_unit
  import edge_stamp_pkg::*;
#(
  parameter int W       = 16,
  parameter int SYNC_N  = 2,
  parameter int RUN_LEN = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_pin,
  input  logic [W-1:0] tmr_count,
  input  logic [1:0]   wave_lo,
  input  logic         cfg_we,
  input  logic [7:0]   cfg_wdata,
  output logic [7:0]   cfg_rdata,
  input  logic         flag_clr,
  input  logic         cap_ie,
  output logic [2:0]   clk_sel,
  output logic [W-1:0] cap_value,
  output logic         cap_flag,
  output logic         cap_irq
);
  es_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_from_byte(cfg_wdata);
  end

  assign cfg_rdata = cfg_to_byte(cfg_q);
  assign clk_sel   = cfg_q.clk_sel;

  // Named internal events for the checker.
  logic sync_lvl, filt_lvl, sel_lvl, cap_is_top, cap_set_evt;

  es_pin_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(cap_pin), .lvl(sync_lvl));

  es_glitch_filter #(.RUN_LEN(RUN_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n), .smp(sync_lvl), .lvl(filt_lvl));

  assign sel_lvl    = cfg_q.filt_en ? filt_lvl : sync_lvl;
  assign cap_is_top = mode_uses_cap_top({cfg_q.wave_hi, wave_lo});

  es_edge_detect u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sel_lvl), .want_rise(cfg_q.edge_rise),
    .enable(~cap_is_top), .hit(cap_set_evt));

  es_cap_store #(.W(W)) u_store (
    .clk(clk), .rst_n(rst_n), .set_evt(cap_set_evt), .clr(flag_clr),
    .count(tmr_count), .value(cap_value), .flag(cap_flag));

  assign cap_irq = cap_flag & cap_ie;
endmodule

// File: rtl/edge_stamp_chk.sv
module edge_stamp_chk
  import edge_stamp_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [7:0]   cfg_rdata,
  input logic [1:0]   wave_lo,
  input logic         flag_clr,
  input logic         cap_ie,
  input logic [W-1:0] cap_value,
  input logic         cap_flag,
  input logic         cap_irq,
  input logic         sync_lvl,
  input logic         filt_lvl,
  input logic         cap_set_evt
);
  logic top_mode;
  assign top_mode = mode_uses_cap_top({cfg_rdata[4:3], wave_lo});

  a_r3_value_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_value) |-> cap_flag);

  a_r6_filter_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt_lvl) |-> $past(sync_lvl));

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cap_set_evt |=> cap_flag);

  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !cap_set_evt) |=> !cap_flag);

  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cap_irq |-> (cap_flag && cap_ie));

  a_r10_top_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    top_mode |=> $stable(cap_value));
endmodule

bind edge_stamp_unit edge_stamp_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .wave_lo(wave_lo),
  .flag_clr(flag_clr), .cap_ie(cap_ie), .cap_value(cap_value),
  .cap_flag(cap_flag), .cap_irq(cap_irq), .sync_lvl(sync_lvl),
  .filt_lvl(filt_lvl), .cap_set_evt(cap_set_evt));

// File: tb/sim_edge_stamp_unit.sv
module sim_edge_stamp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_pin = 1'b0;
  logic [15:0] tcount = 16'h1000;
  logic [1:0]  wave_lo = 2'b00;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        flag_clr = 1'b0;
  logic        cap_ie = 1'b0;
  logic [2:0]  clk_sel;
  logic [15:0] cap_value;
  logic        cap_flag;
  logic        cap_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) tcount <= tcount + 16'd1;

  edge_stamp_unit u0 (
    .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .tmr_count(tcount),
    .wave_lo(wave_lo), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .flag_clr(flag_clr), .cap_ie(cap_ie),
    .clk_sel(clk_sel), .cap_value(cap_value), .cap_flag(cap_flag),
    .cap_irq(cap_irq));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [7:0] b);
    cfg_we = 1'b1; cfg_wdata = b;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
  endtask

  function automatic bit top_mode(input logic [3:0] m);
    return (m == 4'd8) || (m == 4'd10) || (m == 4'd12) || (m == 4'd14);
  endfunction

  task automatic t_reset();
    chk(cfg_rdata == 8'h00, "R1", "cfg", cfg_rdata, 0);
    chk(cap_value == 16'h0, "R1", "value", cap_value, 0);
    chk(!cap_flag && !cap_irq, "R1", "flag/irq", {cap_flag, cap_irq}, 0);
  endtask

  task automatic t_layout();
    wr_cfg(8'hFF);
    chk(cfg_rdata == 8'hDF, "R2", "rdata FF", cfg_rdata, 8'hDF);
    chk(clk_sel == 3'd7, "R2", "clk_sel", clk_sel, 7);
    wr_cfg(8'h2A);
    chk(cfg_rdata == 8'h0A, "R2", "rdata 2A", cfg_rdata, 8'h0A);
    chk(clk_sel == 3'd2, "R2", "clk_sel", clk_sel, 2);
    wr_cfg(8'h40);
  endtask

  task automatic t_unfilt_rise();
    logic [15:0] v;
    clear_flag();
    cap_pin = 1'b1; v = tcount;
    step(2);
    chk(!cap_flag, "R3", "flag early", cap_flag, 0);
    step(1);
    chk(cap_flag, "R3", "flag on time", cap_flag, 1);
    chk(cap_value == v + 16'd2, "R3", "stamp", cap_value, v + 16'd2);
    // Falling edge with rise select is ignored.
    clear_flag();
    v = cap_value;
    cap_pin = 1'b0;
    step(6);
    chk(!cap_flag && cap_value == v, "R4", "fall ignored", cap_flag, 0);
  endtask

  task automatic t_fall_select();
    logic [15:0] v;
    wr_cfg(8'h00);
    cap_pin = 1'b1;
    step(6);
    chk(!cap_flag, "R4", "rise ignored in fall mode", cap_flag, 0);
    cap_pin = 1'b0; v = tcount;
    step(3);
    chk(cap_flag && cap_value == v + 16'd2, "R4", "fall stamp", cap_value, v + 16'd2);
  endtask

  task automatic t_filter_delay();
    logic [15:0] v;
    wr_cfg(8'hC0);
    step(2);
    clear_flag();
    cap_pin = 1'b1; v = tcount;
    step(6);
    chk(!cap_flag, "R5", "filtered flag early", cap_flag, 0);
    step(1);
    chk(cap_flag, "R5", "filtered flag", cap_flag, 1);
    chk(cap_value == v + 16'd6, "R5", "filtered stamp", cap_value, v + 16'd6);
    cap_pin = 1'b0;
    step(8);
  endtask

  task automatic t_filter_glitch();
    clear_flag();
    cap_pin = 1'b1; step(3);
    cap_pin = 1'b0; step(10);
    chk(!cap_flag, "R6", "short pulse", cap_flag, 0);
    cap_pin = 1'b1; step(3);
    cap_pin = 1'b0; step(1);
    cap_pin = 1'b1; step(3);
    cap_pin = 1'b0; step(10);
    chk(!cap_flag, "R11", "run restart", cap_flag, 0);
  endtask

  task automatic t_top_modes();
    logic [15:0] v;
    for (int m = 8; m < 16; m++) begin
      logic [3:0] mm;
      mm = 4'(m);
      if (!top_mode(mm)) continue;
      wave_lo = mm[1:0];
      wr_cfg({3'b010, mm[3:2], 3'b000});
      clear_flag();
      v = cap_value;
      cap_pin = 1'b1; step(6);
      chk(!cap_flag && cap_value == v, "R10", "top mode blocks", m, 0);
      cap_pin = 1'b0; step(4);
    end
    wave_lo = 2'b01;
    wr_cfg(8'h50);
    clear_flag();
    cap_pin = 1'b1; v = tcount;
    step(3);
    chk(cap_flag && cap_value == v + 16'd2, "R10", "mode 9 captures",
        cap_value, v + 16'd2);
  endtask

  task automatic t_edge_toggle();
    clear_flag();
    wr_cfg(8'h10);
    wr_cfg(8'h50);
    wr_cfg(8'h10);
    step(5);
    chk(!cap_flag, "R9", "polarity write", cap_flag, 0);
  endtask

  task automatic t_irq_race();
    // Pin is high, fall select: capture lands on the third edge.
    clear_flag();
    cap_pin = 1'b0;
    step(2);
    flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
    chk(cap_flag, "R7", "set beats clear", cap_flag, 1);
    cap_ie = 1'b0; step(1);
    chk(!cap_irq, "R8", "irq masked", cap_irq, 0);
    cap_ie = 1'b1; step(1);
    chk(cap_irq, "R8", "irq raised", cap_irq, 1);
    clear_flag();
    chk(!cap_flag, "R7", "clear", cap_flag, 0);
    chk(!cap_irq, "R8", "irq drops", cap_irq, 0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_layout();
    t_unfilt_rise();
    t_fall_select();
    t_filter_delay();
    t_filter_glitch();
    t_top_modes();
    t_edge_toggle();
    t_irq_race();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule